// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache that sits between a requester and a slower backing memory. Every stored block may live in either of two ways of the set that its address selects. Both ways' tags are compared with the request at the same time. A two-input multiplexer passes the hitting way's block to a byte selector, which returns one byte.

On a miss, the cache asks the backing memory for the whole block and waits as long as the memory needs. It writes the block into the set and then answers the request from the new contents. Each set keeps one replacement bit that names its least recently used way. Hits and fills both update that bit. A fill always uses an empty way when the set still has one, and evicts only when both ways are valid.

The number of sets, the block size and the address width are parameters. Requests are accepted one at a time.

Top module: `cache2w_top`

## Requirements
- R1: The address splits into three fields. The byte offset is the low OFF_W bits (address mod 2^OFF_W). The set is the next SET_W bits ((address / 2^OFF_W) mod 2^SET_W). The tag is the remaining upper bits. With the defaults (16-bit address, 16-byte blocks, 4 sets), byte address 6195 selects set 3, and the byte returned is byte `offset` of the stored block.
- R2: After reset no way is valid. `req_ready` is 1, and `resp_valid` and `mem_req` are 0. The first access to any set misses.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. A hit raises `resp_valid` in the cycle right after acceptance, with `resp_was_hit`=1 and the correct byte, and no memory request is made.
- R4: On a miss, `mem_req` rises with `mem_addr` equal to the block address (address / 2^OFF_W). Both hold steady until `mem_ack`. The response follows the fill with `resp_was_hit`=0 and the requested byte of the fetched block.
- R5: A fill uses an invalid way of the target set whenever one exists. A block that is already resident is never evicted while its set still has an empty way.
- R6: When both ways of the set are valid, a miss replaces the least recently used way.
- R7: A hit makes the hitting way the most recently used one of its set. A fill does the same for the filled way.
- R8: Within one set, the tag stream A B A C B A B gives miss, miss, hit, miss, miss, miss, hit.
- R9: The two ways of a set never both match the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ready | output | 1 | Cache is idle and takes a request |
| resp_valid | output | 1 | Response byte is valid this cycle |
| resp_data | output | 8 | Requested byte |
| resp_was_hit | output | 1 | 1 if the request hit without a fill |
| mem_req | output | 1 | Block fetch request to the backing memory |
| mem_addr | output | ADDR_W-OFF_W | Block address to fetch |
| mem_ack | input | 1 | Backing memory delivers the block this cycle |
| mem_data | input | 8<<OFF_W | Fetched block, byte i in bits 8i+7:8i |

## Verification
Several access patterns are used, and each separates a different kind of faulty design:

- The tag stream A B A C B A B in one set separates true LRU from FIFO or fixed-way replacement.
- Filling two blocks into a fresh set and then rereading the first one separates empty-way preference from blind eviction.
- A hit followed by a miss in a full set shows whether hits update the replacement state.
- Reading the 6195 block, then filling a neighbouring set and rereading, checks the address split.
- A long pseudo-random stream over a few tags per set is compared against a behavioural model on every response. It covers byte selection across all offsets and the interleaving of sets.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2
    } cstate_e;

    typedef struct packed {
        logic valid0;
        logic valid1;
        logic lru;
    } set_view_t;

    // Victim choice: an empty way first (way 0 before way 1), else the LRU way.
    function automatic logic pick_victim(input set_view_t sv);
        if (!sv.valid0)      return 1'b0;
        else if (!sv.valid1) return 1'b1;
        else                 return sv.lru;
    endfunction

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
    parameter int SET_W    = 2,
    parameter int TAG_W    = 10,
    parameter int BLK_BITS = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SET_W-1:0]    rd_set,
    input  logic [TAG_W-1:0]    cmp_tag,
    input  logic                wr_en,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [BLK_BITS-1:0] wr_blk,
    output logic                valid,
    output logic                match,
    output logic [BLK_BITS-1:0] blk
);
    localparam int SETS = 1 << SET_W;

    logic                valid_q [SETS];
    logic [TAG_W-1:0]    tag_q   [SETS];
    logic [BLK_BITS-1:0] blk_q   [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) valid_q[i] <= 1'b0;
        end else if (wr_en) begin
            valid_q[rd_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[rd_set] <= wr_tag;
            blk_q[rd_set] <= wr_blk;
        end
    end

    assign valid = valid_q[rd_set];
    assign match = valid_q[rd_set] && (tag_q[rd_set] == cmp_tag);
    assign blk   = blk_q[rd_set];
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
    parameter int SET_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic             upd_en,
    input  logic             used_way,
    output logic             lru_way
);
    localparam int SETS = 1 << SET_W;

    logic lru_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) lru_q[i] <= 1'b0;
        end else if (upd_en) begin
            lru_q[set_idx] <= ~used_way;
        end
    end

    assign lru_way = lru_q[set_idx];
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic hit_any,
    input  logic mem_ack,
    output logic req_ready,
    output logic accept,
    output logic looking,
    output logic filling,
    output logic missed
);
    cstate_e state_q, state_d;
    logic    missed_q;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign looking   = (state_q == ST_LOOK);
    assign filling   = (state_q == ST_FILL);
    assign missed    = missed_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOOK;
            ST_LOOK: state_d = hit_any ? ST_IDLE : ST_FILL;
            ST_FILL: if (mem_ack) state_d = ST_LOOK;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            missed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept)                missed_q <= 1'b0;
            else if (filling && mem_ack) missed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SET_W  = 2,
    parameter int OFF_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic                      req_ready,
    output logic                      resp_valid,
    output logic [7:0]                resp_data,
    output logic                      resp_was_hit,
    output logic                      mem_req,
    output logic [ADDR_W-OFF_W-1:0]   mem_addr,
    input  logic                      mem_ack,
    input  logic [(8<<OFF_W)-1:0]     mem_data
);
    localparam int TAG_W    = ADDR_W - SET_W - OFF_W;
    localparam int BLK_BITS = 8 << OFF_W;
    localparam int WAYS     = 2;

    logic [ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]  cur_tag;
    logic [SET_W-1:0]  cur_set;
    logic [OFF_W-1:0]  cur_off;

    assign cur_tag = addr_q[ADDR_W-1 -: TAG_W];
    assign cur_set = addr_q[OFF_W +: SET_W];
    assign cur_off = addr_q[OFF_W-1:0];

    logic accept, looking, filling, missed;
    logic hit_any, hit_way, lru_way, fill_en, fill_way, hit_fire;
    logic [WAYS-1:0]     vld_w, hit_w, wr_w;
    logic [BLK_BITS-1:0] blk_w [WAYS];
    logic [BLK_BITS-1:0] sel_blk;
    set_view_t           view;

    always_ff @(posedge clk) begin
        if (rst)         addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    cache2w_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .hit_any   (hit_any),
        .mem_ack   (mem_ack),
        .req_ready (req_ready),
        .accept    (accept),
        .looking   (looking),
        .filling   (filling),
        .missed    (missed)
    );

    assign view     = '{valid0: vld_w[0], valid1: vld_w[1], lru: lru_way};
    assign fill_en  = filling && mem_ack;
    assign fill_way = pick_victim(view);

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign wr_w[g] = fill_en && (fill_way == g[0]);
        cache2w_way #(
            .SET_W    (SET_W),
            .TAG_W    (TAG_W),
            .BLK_BITS (BLK_BITS)
        ) u_way (
            .clk     (clk),
            .rst     (rst),
            .rd_set  (cur_set),
            .cmp_tag (cur_tag),
            .wr_en   (wr_w[g]),
            .wr_tag  (cur_tag),
            .wr_blk  (mem_data),
            .valid   (vld_w[g]),
            .match   (hit_w[g]),
            .blk     (blk_w[g])
        );
    end

    assign hit_any  = |hit_w;
    assign hit_way  = hit_w[1];
    assign sel_blk  = hit_way ? blk_w[1] : blk_w[0];
    assign hit_fire = looking && hit_any;

    cache2w_lru #(.SET_W(SET_W)) u_lru (
        .clk      (clk),
        .rst      (rst),
        .set_idx  (cur_set),
        .upd_en   (hit_fire || fill_en),
        .used_way (fill_en ? fill_way : hit_way),
        .lru_way  (lru_way)
    );

    assign resp_valid   = hit_fire;
    assign resp_data    = sel_blk[{cur_off, 3'b000} +: 8];
    assign resp_was_hit = !missed;
    assign mem_req      = filling;
    assign mem_addr     = addr_q[ADDR_W-1:OFF_W];
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
    parameter int BADDR_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_was_hit,
    input logic               mem_req,
    input logic               mem_ack,
    input logic [BADDR_W-1:0] mem_addr,
    input logic [1:0]         vld_w,
    input logic [1:0]         hit_w,
    input logic               lru_way,
    input logic               fill_en,
    input logic               fill_way,
    input logic               hit_way,
    input logic               hit_fire
);
    a_r9_single_match: assert property (@(posedge clk) disable iff (rst)
        !(hit_w[0] && hit_w[1]));

    a_r4_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r3_hit_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_was_hit) |-> !mem_req);

    a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (resp_valid || mem_req) |-> !req_ready);

    a_r5_empty_first: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !(vld_w[0] && vld_w[1])) |-> !vld_w[fill_way]);

    a_r6_evict_lru: assert property (@(posedge clk) disable iff (rst)
        (fill_en && vld_w[0] && vld_w[1]) |-> (fill_way == lru_way));

    a_r7_hit_mru: assert property (@(posedge clk) disable iff (rst)
        hit_fire |=> (lru_way == !$past(hit_way)));
endmodule

bind cache2w_top cache2w_chk #(.BADDR_W(ADDR_W - OFF_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_was_hit (resp_was_hit),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .vld_w        (vld_w),
    .hit_w        (hit_w),
    .lru_way      (lru_way),
    .fill_en      (fill_en),
    .fill_way     (fill_way),
    .hit_way      (hit_way),
    .hit_fire     (hit_fire)
);

// File: tb/cache2w_top_tb.sv
`timescale 1ns/1ps
module cache2w_top_tb;
    localparam int ADDR_W = 16;
    localparam int SET_W  = 2;
    localparam int OFF_W  = 4;
    localparam int SETS   = 1 << SET_W;
    localparam int BLK_B  = 1 << OFF_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, resp_valid, resp_was_hit, mem_req;
    logic [7:0] resp_data;
    logic [ADDR_W-OFF_W-1:0] mem_addr;
    logic mem_ack = 1'b0;
    logic [(8<<OFF_W)-1:0] mem_data = '0;

    int total = 0;
    int bad   = 0;
    int fetches = 0;
    int wait_cnt = 0;
    int exp_baddr = -1;
    bit finished = 0;

    // behavioural reference state
    int  m_tag [SETS][2];
    bit  m_vld [SETS][2];
    bit  m_lru [SETS];

    always #2 clk = ~clk;

    cache2w_top #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_was_hit(resp_was_hit), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data)
    );

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 37) ^ (a >> 8) ^ 8'h5a);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Backing memory: answers three cycles after seeing a request, checks address (R4).
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            wait_cnt++;
            if (wait_cnt == 1) chk(int'(mem_addr) == exp_baddr, "R4 mem_addr", int'(mem_addr), exp_baddr);
            if (wait_cnt == 3) begin
                for (int b = 0; b < BLK_B; b++)
                    mem_data[8*b +: 8] = mem_byte(int'(mem_addr) * BLK_B + b);
                mem_ack  = 1'b1;
                wait_cnt = 0;
                fetches++;
            end
        end
    end

    // One read; returns hit flag seen. Model compared on the response.
    task automatic access(input int a, output bit got_hit);
        int  set, tg, f0, lat, way;
        bit  e_hit;
        set = (a >> OFF_W) % SETS;
        tg  = a >> (OFF_W + SET_W);
        e_hit = 0; way = 0;
        for (int w = 0; w < 2; w++)
            if (m_vld[set][w] && m_tag[set][w] == tg) begin e_hit = 1; way = w; end
        if (!e_hit) way = !m_vld[set][0] ? 0 : (!m_vld[set][1] ? 1 : int'(m_lru[set]));
        m_vld[set][way] = 1; m_tag[set][way] = tg; m_lru[set] = !way[0];
        exp_baddr = a >> OFF_W;
        f0 = fetches;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = ADDR_W'(a);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 100) begin @(negedge clk); lat++; end
        chk(resp_valid == 1'b1, "R3 response arrives", int'(resp_valid), 1);
        chk(resp_was_hit == e_hit, "R6 R7 hit/miss vs model", int'(resp_was_hit), int'(e_hit));
        chk(resp_data == mem_byte(a), "R1 byte select", int'(resp_data), int'(mem_byte(a)));
        if (e_hit) begin
            chk(lat == 1, "R3 hit latency", lat, 1);
            chk(fetches == f0, "R3 no fetch on hit", fetches - f0, 0);
        end else begin
            chk(fetches == f0 + 1, "R4 one fetch on miss", fetches - f0, 1);
        end
        got_hit = resp_was_hit;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit h;
        bit exp_seq [7] = '{0, 0, 1, 0, 0, 0, 1};
        int seq_tag [7] = '{0, 1, 0, 2, 1, 0, 1};
        int lfsr = 16'hACE1;
        for (int s = 0; s < SETS; s++) begin
            m_lru[s] = 0; m_vld[s][0] = 0; m_vld[s][1] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R2 reset state
        chk(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R2 no response after reset", int'(resp_valid), 0);
        chk(mem_req == 1'b0, "R2 no fetch after reset", int'(mem_req), 0);

        // R1: 6195 -> set 3, block 387
        access(6195, h); chk(h == 0, "R2 first access misses", int'(h), 0);
        chk(((6195 >> OFF_W) % SETS) == 3, "R1 6195 set index", (6195 >> OFF_W) % SETS, 3);
        access(6192, h); chk(h == 1, "R1 same block other offset hits", int'(h), 1);
        access(32'h0020, h); access(32'h0420, h); // fill set 2 fully
        access(6195, h); chk(h == 1, "R1 set 3 untouched by set 2", int'(h), 1);

        // R8 stream in set 0: tags A=0, B=1, C=2
        for (int i = 0; i < 7; i++) begin
            access((seq_tag[i] << (OFF_W + SET_W)) + i, h);
            chk(h == exp_seq[i], "R8 A B A C B A B", int'(h), int'(exp_seq[i]));
        end

        // R5: set 1, fill X then Y, X must survive
        access(16'h0110, h);
        access(16'h0510, h);
        access(16'h0111, h); chk(h == 1, "R5 empty way used before eviction", int'(h), 1);
        // R7 then R6: X is MRU now, Z evicts Y
        access(16'h0913, h); chk(h == 0, "R6 new tag misses", int'(h), 0);
        access(16'h0114, h); chk(h == 1, "R7 hit kept X resident", int'(h), 1);
        access(16'h0515, h); chk(h == 0, "R6 LRU way Y evicted", int'(h), 0);

        // pseudo-random stream, model compared per response
        for (int n = 0; n < 300; n++) begin
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
            access(((lfsr % 3) << 12) | (lfsr & 16'h003F), h);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule